// File: doc/BRIEF.md
# Memory Operation Ordering Queue

This block sits beside the dispatch stage of an out-of-order core and holds every memory operation that is in flight. Loads go into a load queue and stores into a store queue. Each cycle the block decides, entry by entry, which queued operations may be sent to execution under a relaxed ordering model. Dispatch supplies three flags with each operation: may-load, may-store and side-effect. The block returns the slot index it allocated in each queue, so that the execution side can later report completion by that index.

An operation that has the side-effect flag set is an ordering barrier rather than an access. It is a load barrier, a store barrier or a full barrier, depending on its access flags. A barrier never receives issue permission. It retires by itself once it is the oldest entry in the queue or queues that it occupies. One configuration input declares that loads never alias stores, which lets loads run ahead of older stores. Address comparison, caching and forwarding are done elsewhere.

Top module: `mem_order_queue`

## Requirements
- R1: After reset both queues are empty, both full flags are low, no entry has issue permission, and `disp_ready` is high.
- R2: An accepted operation takes one load-queue slot when `disp_may_load` is set and one store-queue slot when `disp_may_store` is set, or one of each when both are set. The slot taken in each queue is the lowest free index, shown on `disp_lq_idx` / `disp_sq_idx`. A full flag is high while every slot of that queue is occupied. `disp_ready` is low, and nothing is allocated, when any queue the operation needs is full.
- R3: A store entry has permission only while no valid entry of either queue is older than it, whatever `noalias_en` holds.
- R4: A load may run ahead of an older load only if no store entry and no barrier entry is younger than that older load and older than itself.
- R5: With `noalias_en` high, a load may run ahead of older stores. With it low, a load waits while any older non-barrier store entry is valid.
- R6: Setting `disp_side_fx` makes the operation a barrier. With may-load only it is a load barrier in the load queue. With may-store only it is a store barrier in the store queue. With both it is a full barrier holding one slot in each queue. Barrier entries never get issue permission.
- R7: A barrier frees its slot or slots one cycle after it becomes the oldest valid entry of its own queue. A full barrier must be the oldest in both queues.
- R8: A load waits while an older load barrier or full barrier is present. A store waits while an older store barrier or full barrier is present.
- R9: A completion frees the named slot whatever its age. A completion naming an empty slot or a barrier slot is ignored.
- R10: An operation with neither may-load nor may-store allocates nothing and is never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| noalias_en | input | 1 | Loads assumed not to alias stores |
| disp_valid | input | 1 | Dispatch offers an operation |
| disp_may_load | input | 1 | Operation reads memory |
| disp_may_store | input | 1 | Operation writes memory |
| disp_side_fx | input | 1 | Operation has unmodelled side effects (barrier) |
| disp_ready | output | 1 | Operation can be accepted this cycle |
| disp_lq_idx | output | LQ_IW | Load-queue slot taken by the offered operation |
| disp_sq_idx | output | SQ_IW | Store-queue slot taken by the offered operation |
| cmp_ld_valid | input | 1 | Load-queue completion |
| cmp_ld_idx | input | LQ_IW | Slot completed in the load queue |
| cmp_st_valid | input | 1 | Store-queue completion |
| cmp_st_idx | input | SQ_IW | Slot completed in the store queue |
| lq_full | output | 1 | Load queue has no free slot |
| sq_full | output | 1 | Store queue has no free slot |
| lq_issue_ok | output | LQ_DEPTH | Per-slot issue permission, load queue |
| sq_issue_ok | output | SQ_DEPTH | Per-slot issue permission, store queue |

## Verification
A wrong relative age between two entries shows up on the permission vectors in the same cycle. A store gains permission beside an older load, or a load stays blocked after its blocker has completed. A barrier that is freed too early or too late shows as a younger load or store whose permission changes one cycle off from the expected cycle. The bench therefore samples permission after every completion, and once more a cycle later. A slot that leaks or is allocated twice shows on the full flags and on the returned index of the next dispatch.

// File: rtl/mem_order_queue.sv
module mem_order_queue #(
  parameter int LQ_DEPTH = 4,
  parameter int SQ_DEPTH = 4,
  localparam int LQ_IW = (LQ_DEPTH > 1) ? $clog2(LQ_DEPTH) : 1,
  localparam int SQ_IW = (SQ_DEPTH > 1) ? $clog2(SQ_DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                noalias_en,
  input  logic                disp_valid,
  input  logic                disp_may_load,
  input  logic                disp_may_store,
  input  logic                disp_side_fx,
  output logic                disp_ready,
  output logic [LQ_IW-1:0]    disp_lq_idx,
  output logic [SQ_IW-1:0]    disp_sq_idx,
  input  logic                cmp_ld_valid,
  input  logic [LQ_IW-1:0]    cmp_ld_idx,
  input  logic                cmp_st_valid,
  input  logic [SQ_IW-1:0]    cmp_st_idx,
  output logic                lq_full,
  output logic                sq_full,
  output logic [LQ_DEPTH-1:0] lq_issue_ok,
  output logic [SQ_DEPTH-1:0] sq_issue_ok
);
  localparam int N = LQ_DEPTH + SQ_DEPTH;

  logic [N-1:0] vld, bar, fbar, ok, retire;
  logic [N-1:0] older [N];
  logic         accept, alloc_l, alloc_s;
  int           l_slot, s_slot;

  assign lq_full = &vld[LQ_DEPTH-1:0];
  assign sq_full = &vld[N-1:LQ_DEPTH];
  assign disp_ready = !(disp_may_load && lq_full) && !(disp_may_store && sq_full);
  assign accept  = disp_valid && disp_ready;
  assign alloc_l = accept && disp_may_load;
  assign alloc_s = accept && disp_may_store;

  always_comb begin
    l_slot = 0;
    s_slot = LQ_DEPTH;
    for (int i = LQ_DEPTH - 1; i >= 0; i--)
      if (!vld[i]) l_slot = i;
    for (int i = N - 1; i >= LQ_DEPTH; i--)
      if (!vld[i]) s_slot = i;
  end

  assign disp_lq_idx = LQ_IW'(l_slot);
  assign disp_sq_idx = SQ_IW'(s_slot - LQ_DEPTH);

  always_comb begin
    logic blk;
    for (int i = 0; i < N; i++) begin
      ok[i] = 1'b0;
      retire[i] = 1'b0;
      blk = 1'b0;
      if (vld[i]) begin
        for (int j = 0; j < N; j++) begin
          if (vld[j] && older[j][i]) begin
            if (bar[i]) begin
              if (((j < LQ_DEPTH) == (i < LQ_DEPTH)) || fbar[i]) blk = 1'b1;
            end else if (i >= LQ_DEPTH) begin
              blk = 1'b1;
            end else begin
              if (j < LQ_DEPTH && bar[j]) blk = 1'b1;
              if (j >= LQ_DEPTH && !bar[j] && !noalias_en) blk = 1'b1;
              if (j < LQ_DEPTH)
                for (int k = 0; k < N; k++)
                  if (vld[k] && older[k][i] && older[j][k] && (k >= LQ_DEPTH || bar[k]))
                    blk = 1'b1;
            end
          end
        end
        if (bar[i]) retire[i] = !blk;
        else        ok[i] = !blk;
      end
    end
  end

  assign lq_issue_ok = ok[LQ_DEPTH-1:0];
  assign sq_issue_ok = ok[N-1:LQ_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= '0;
      bar  <= '0;
      fbar <= '0;
      for (int k = 0; k < N; k++) older[k] <= '0;
    end else begin
      for (int k = 0; k < N; k++)
        if (retire[k]) vld[k] <= 1'b0;
      if (cmp_ld_valid && !bar[int'(cmp_ld_idx)])
        vld[int'(cmp_ld_idx)] <= 1'b0;
      if (cmp_st_valid && !bar[LQ_DEPTH + int'(cmp_st_idx)])
        vld[LQ_DEPTH + int'(cmp_st_idx)] <= 1'b0;
      if (alloc_l) begin
        vld[l_slot]  <= 1'b1;
        bar[l_slot]  <= disp_side_fx;
        fbar[l_slot] <= disp_side_fx && disp_may_store;
        for (int j = 0; j < N; j++) begin
          older[l_slot][j] <= 1'b0;
          older[j][l_slot] <= vld[j];
        end
      end
      if (alloc_s) begin
        vld[s_slot]  <= 1'b1;
        bar[s_slot]  <= disp_side_fx;
        fbar[s_slot] <= disp_side_fx && disp_may_load;
        for (int j = 0; j < N; j++) begin
          older[s_slot][j] <= 1'b0;
          older[j][s_slot] <= vld[j];
        end
      end
    end
  end

  AST_SINGLE_STORE_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sq_issue_ok) <= 1); // R3

  AST_NO_GROWTH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_may_load && lq_full) |=>
      $countones(vld[LQ_DEPTH-1:0]) <= $past($countones(vld[LQ_DEPTH-1:0]))); // R2

  AST_COMPLETION_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_ld_valid && vld[int'(cmp_ld_idx)] && !bar[int'(cmp_ld_idx)]) |=>
      !vld[int'($past(cmp_ld_idx))]); // R9

  AST_PERMIT_ON_LIVE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    ((lq_issue_ok & ~(vld[LQ_DEPTH-1:0] & ~bar[LQ_DEPTH-1:0])) == '0)); // R6

  AST_FULL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lq_full) |-> $past(disp_valid && disp_may_load)); // R2
endmodule

// File: tb/test_mem_order_queue.sv
`timescale 1ns/1ps
module test_mem_order_queue;
  logic clk = 1'b0, rst_n = 1'b0, noalias_en = 1'b1;
  logic disp_valid = 1'b0, disp_may_load = 1'b0, disp_may_store = 1'b0, disp_side_fx = 1'b0;
  logic disp_ready, lq_full, sq_full;
  logic [1:0] disp_lq_idx, disp_sq_idx;
  logic cmp_ld_valid = 1'b0, cmp_st_valid = 1'b0;
  logic [1:0] cmp_ld_idx = '0, cmp_st_idx = '0;
  logic [3:0] lq_issue_ok, sq_issue_ok;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mem_order_queue i_mem_order_queue (
    .clk(clk), .rst_n(rst_n), .noalias_en(noalias_en),
    .disp_valid(disp_valid), .disp_may_load(disp_may_load),
    .disp_may_store(disp_may_store), .disp_side_fx(disp_side_fx),
    .disp_ready(disp_ready), .disp_lq_idx(disp_lq_idx), .disp_sq_idx(disp_sq_idx),
    .cmp_ld_valid(cmp_ld_valid), .cmp_ld_idx(cmp_ld_idx),
    .cmp_st_valid(cmp_st_valid), .cmp_st_idx(cmp_st_idx),
    .lq_full(lq_full), .sq_full(sq_full),
    .lq_issue_ok(lq_issue_ok), .sq_issue_ok(sq_issue_ok));

  // {may_load, may_store, side_fx, exp_ready, chk_l, l_idx[1:0], chk_s, s_idx[1:0]}
  localparam logic [9:0] VEC [12] = '{
    10'b1_0_0_1_1_00_0_00, 10'b0_1_0_1_0_00_1_00, 10'b1_0_0_1_1_01_0_00,
    10'b1_1_0_1_1_10_1_01, 10'b1_0_0_1_1_11_0_00, 10'b1_0_0_0_0_00_0_00,
    10'b0_1_0_1_0_00_1_10, 10'b0_1_0_1_0_00_1_11, 10'b0_1_0_0_0_00_0_00,
    10'b1_1_0_0_0_00_0_00, 10'b0_0_0_1_0_00_0_00, 10'b0_0_1_1_0_00_0_00};

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic disp(input logic ml, ms, sf, output logic rdy,
                      output logic [1:0] li, si);
    @(negedge clk);
    disp_valid = 1'b1; disp_may_load = ml; disp_may_store = ms; disp_side_fx = sf;
    #1 rdy = disp_ready; li = disp_lq_idx; si = disp_sq_idx;
    @(posedge clk); #1 disp_valid = 1'b0;
  endtask

  task automatic cmp(input logic lv, input logic [1:0] li, input logic sv,
                     input logic [1:0] si);
    @(negedge clk);
    cmp_ld_valid = lv; cmp_ld_idx = li; cmp_st_valid = sv; cmp_st_idx = si;
    @(posedge clk); #1 cmp_ld_valid = 1'b0; cmp_st_valid = 1'b0;
  endtask

  task automatic perm(input string req, input int el, input int es);
    chk({req, " lq_issue_ok"}, int'(lq_issue_ok), el);
    chk({req, " sq_issue_ok"}, int'(sq_issue_ok), es);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic r;
    logic [1:0] li, si;
    #20 rst_n = 1'b1;
    step();
    chk("R1 lq_full", int'(lq_full), 0);
    chk("R1 sq_full", int'(sq_full), 0);
    chk("R1 disp_ready", int'(disp_ready), 1);
    perm("R1", 0, 0);

    for (int v = 0; v < 12; v++) begin
      disp(VEC[v][9], VEC[v][8], VEC[v][7], r, li, si);
      chk($sformatf("R2 row%0d ready", v), int'(r), int'(VEC[v][6]));
      if (VEC[v][5]) chk($sformatf("R2 row%0d lq idx", v), int'(li), int'(VEC[v][4:3]));
      if (VEC[v][2]) chk($sformatf("R2 row%0d sq idx", v), int'(si), int'(VEC[v][1:0]));
    end
    chk("R2 lq_full", int'(lq_full), 1);
    chk("R2 sq_full", int'(sq_full), 1);
    perm("R4 store between loads", 4'b0001, 4'b0000);

    cmp(1'b1, 2'd0, 1'b0, 2'd0);
    perm("R5 noalias on", 4'b0110, 4'b0001);
    @(negedge clk) noalias_en = 1'b0; #1;
    perm("R5 noalias off", 4'b0000, 4'b0001);
    @(negedge clk) noalias_en = 1'b1; #1;
    cmp(1'b0, 2'd0, 1'b1, 2'd0);
    perm("R9 out of order", 4'b0110, 4'b0000);
    cmp(1'b1, 2'd2, 1'b1, 2'd1);
    perm("R4 pass after store gone", 4'b1010, 4'b0000);
    cmp(1'b1, 2'd2, 1'b1, 2'd1);
    perm("R9 empty completion", 4'b1010, 4'b0000);
    cmp(1'b1, 2'd1, 1'b0, 2'd0);
    perm("R3 store waits", 4'b1000, 4'b0000);
    cmp(1'b1, 2'd3, 1'b0, 2'd0);
    perm("R3 oldest store", 4'b0000, 4'b0100);
    cmp(1'b0, 2'd0, 1'b1, 2'd2);
    perm("R3 next store", 4'b0000, 4'b1000);
    cmp(1'b0, 2'd0, 1'b1, 2'd3);
    perm("R9 drained", 0, 0);

    for (int v = 0; v < 4; v++) disp(1'b0, 1'b0, v[0], r, li, si);
    chk("R10 lq_full", int'(lq_full), 0);
    perm("R10 no entry", 0, 0);

    disp(1'b1, 1'b0, 1'b0, r, li, si);
    disp(1'b1, 1'b0, 1'b1, r, li, si);
    chk("R6 load barrier slot", int'(li), 1);
    disp(1'b1, 1'b0, 1'b0, r, li, si);
    disp(1'b0, 1'b1, 1'b0, r, li, si);
    perm("R8 load barrier", 4'b0001, 4'b0000);
    cmp(1'b1, 2'd1, 1'b0, 2'd0);
    perm("R9 barrier completion ignored", 4'b0001, 4'b0000);
    cmp(1'b1, 2'd0, 1'b0, 2'd0);
    perm("R7 barrier oldest", 4'b0000, 4'b0000);
    step();
    perm("R7 barrier freed", 4'b0100, 4'b0000);
    cmp(1'b1, 2'd2, 1'b0, 2'd0);
    cmp(1'b0, 2'd0, 1'b1, 2'd0);

    disp(1'b0, 1'b1, 1'b0, r, li, si);
    disp(1'b0, 1'b1, 1'b1, r, li, si);
    disp(1'b0, 1'b1, 1'b0, r, li, si);
    perm("R8 store barrier", 4'b0000, 4'b0001);
    cmp(1'b0, 2'd0, 1'b1, 2'd0);
    perm("R7 store barrier oldest", 4'b0000, 4'b0000);
    step();
    perm("R7 store barrier freed", 4'b0000, 4'b0100);
    cmp(1'b0, 2'd0, 1'b1, 2'd2);

    disp(1'b1, 1'b0, 1'b0, r, li, si);
    disp(1'b0, 1'b1, 1'b0, r, li, si);
    disp(1'b1, 1'b1, 1'b1, r, li, si);
    chk("R6 full barrier lq slot", int'(li), 1);
    chk("R6 full barrier sq slot", int'(si), 1);
    disp(1'b1, 1'b0, 1'b0, r, li, si);
    perm("R6 full barrier", 4'b0001, 4'b0000);
    cmp(1'b1, 2'd0, 1'b0, 2'd0);
    perm("R7 full barrier held by store", 4'b0000, 4'b0001);
    step();
    perm("R7 full barrier still held", 4'b0000, 4'b0001);
    cmp(1'b0, 2'd0, 1'b1, 2'd0);
    perm("R7 full barrier oldest", 4'b0000, 4'b0000);
    step();
    perm("R7 full barrier freed", 4'b0100, 4'b0000);
    @(negedge clk) disp_valid = 1'b0; disp_may_store = 1'b1; disp_may_load = 1'b0; #1;
    chk("R7 sq slot reusable", int'(disp_sq_idx), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule